// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block watches the write cycles a host issues toward a parallel NOR flash and turns them into the actions the array controller must carry out. It handles the keyed three-write command entry, program arming, the two-stage erase entry (sector or whole chip), identification and query modes, and a bypass mode in which commands are given with a single write. The block holds no storage. It drives a read-mode code for the read mux, a one-cycle program strobe carrying the target address and data, and one-cycle erase strobes. The array applies the program data with a bitwise AND, so a program can only clear bits.

Every write carries a byte address, a data word and a device width code. The block converts the byte offset within a sector into a word index using that width, and checks every keyed index against that word index. After an erase strobe, an external erase timer answers with a one-cycle done pulse. All strobes and the mode code are registered. They change on the clock edge that accepts the write.

Top module: `nor_cmd_seq`

## Requirements
- R1: A synchronous active-low reset sets the read-mode code to array (0), clears bypass and holds every strobe low.
- R2: A keyed index is the byte offset within the sector shifted right by 0, 1 or 2 for width code 0 (8-bit), 1 (16-bit) or 2 (32-bit); code 3 acts as 32-bit. Command entry is data 0xAA at index 0x555, then 0x55 at index 0x2AA, then the command byte at index 0x555; the command byte is wr_data[7:0].
- R3: Any write that breaks the keyed sequence returns the block to array mode, and the command is not executed.
- R4: Command 0xA0 arms a program. The next write raises prog_stb for exactly one cycle with that write's address and full data word, and data 0xF0 in that write is programmed rather than treated as a reset. Only one strobe is ever high at a time.
- R5: Data 0xF0 returns the block to array mode from any state except an armed program or an erase in progress.
- R6: Command 0x90 sets the read-mode code to identification (2). Any following write other than a query entry leaves that mode.
- R7: Data 0x98 at index 0x55 sets the query code (3) from array mode or from identification mode. Any write in query mode returns to array mode.
- R8: Command 0x80 followed by a second 0xAA/0x55 pair and then 0x10 at index 0x555 raises chip_erase_stb for one cycle and sets the status code (1). 0x10 at any other index aborts to array mode.
- R9: The same prefix followed by 0x30 at any address raises sect_erase_stb for one cycle, with sect_base equal to the write address rounded down to a sector boundary, and sets the status code.
- R10: While erasing, all writes, including 0xF0, are ignored. erase_done ends the erase, and a write in the same cycle as erase_done is also ignored.
- R11: Command 0x20 enters bypass. In bypass a command is a single write at any address, and after a program or an erase completes the block waits for the next single-write command.
- R12: In bypass, command 0x90 followed by data 0x00 exits bypass and returns to array mode.
- R13: An unknown command byte returns the block to array mode and clears bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write cycle valid |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; low byte is the command |
| wr_width | input | 2 | Device width code: 0 x8, 1 x16, 2/3 x32 |
| erase_done | input | 1 | One-cycle pulse from the erase timer |
| rd_mode | output | 2 | 0 array, 1 status, 2 identification, 3 query |
| prog_stb | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program byte address |
| prog_data | output | DATA_W | Program data, to be ANDed into the array |
| chip_erase_stb | output | 1 | One-cycle whole-chip erase request |
| sect_erase_stb | output | 1 | One-cycle sector erase request |
| sect_base | output | ADDR_W | Sector-aligned base of the erase |

## Verification
The collision of interest is erase completion arriving in the same cycle as a host write. The bench provokes it in bypass mode by raising erase_done together with a write of 0xA0. If the write were taken, that write would arm a program. The bench then writes a byte that can only produce a program strobe if that arming happened. The scoreboard must see no strobe, and the read-mode code must read array both after the collision and after the follow-up write.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   typedef enum logic [3:0] {
      S_READ, S_UNL1, S_CMD, S_PROG, S_EU0, S_EU1, S_ECMD, S_ERASE, S_AUTO, S_CFI
   } seq_state_t;

   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_STATUS = 2'd1,
      MODE_ID     = 2'd2,
      MODE_CFI    = 2'd3
   } rd_mode_t;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] OP_PROG    = 8'hA0;
   localparam logic [7:0] OP_ERASE   = 8'h80;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_BYPASS  = 8'h20;
   localparam logic [7:0] OP_RESET   = 8'hF0;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_CHIP    = 8'h10;
   localparam logic [7:0] OP_SECT    = 8'h30;
   localparam logic [7:0] OP_BYP_END = 8'h00;

   localparam int unsigned IDX_KEY_A = 'h555;
   localparam int unsigned IDX_KEY_B = 'h2AA;
   localparam int unsigned IDX_QUERY = 'h055;

endpackage

// File: rtl/nor_idx_match.sv
module nor_idx_match
   import nor_seq_pkg::*;
#(
   parameter int SECT_LOG2 = 16
) (
   input  logic [SECT_LOG2-1:0] sect_off,
   input  logic [1:0]           width_code,
   output logic                 hit_key_a,
   output logic                 hit_key_b,
   output logic                 hit_query
);

   localparam int NUM_WIDTHS = 3;

   logic [SECT_LOG2-1:0] idx_by_w [NUM_WIDTHS];
   logic [SECT_LOG2-1:0] idx;
   logic [1:0]           sel;

   for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_shift
      assign idx_by_w[g] = sect_off >> g;
   end

   assign sel = (width_code == 2'd3) ? 2'd2 : width_code;
   assign idx = idx_by_w[sel];

   assign hit_key_a = (idx == SECT_LOG2'(IDX_KEY_A));
   assign hit_key_b = (idx == SECT_LOG2'(IDX_KEY_B));
   assign hit_query = (idx == SECT_LOG2'(IDX_QUERY));

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
   import nor_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] cmd,
   input  logic       hit_key_a,
   input  logic       hit_key_b,
   input  logic       hit_query,
   input  logic       erase_done,
   output logic       go_prog,
   output logic       go_chip,
   output logic       go_sect,
   output logic [1:0] rd_mode
);

   seq_state_t st, st_nxt;
   logic       byp, byp_nxt;
   logic       drop;

   always_comb begin
      st_nxt  = st;
      byp_nxt = byp;
      drop    = 1'b0;
      go_prog = 1'b0;
      go_chip = 1'b0;
      go_sect = 1'b0;
      if (st == S_ERASE) begin
         if (erase_done) st_nxt = byp ? S_CMD : S_READ;
      end else if (wr_en) begin
         if (cmd == OP_RESET && st != S_PROG) begin
            drop = 1'b1;
         end else begin
            case (st)
               S_READ: begin
                  if (hit_query && cmd == OP_QUERY)        st_nxt = S_CFI;
                  else if (hit_key_a && cmd == KEY_FIRST)  st_nxt = S_UNL1;
                  else                                     drop = 1'b1;
               end
               S_UNL1: begin
                  if (hit_key_b && cmd == KEY_SECOND) st_nxt = S_CMD;
                  else                                drop = 1'b1;
               end
               S_CMD: begin
                  if (!byp && !hit_key_a) begin
                     drop = 1'b1;
                  end else begin
                     case (cmd)
                        OP_BYPASS: byp_nxt = 1'b1;
                        OP_PROG:   st_nxt  = S_PROG;
                        OP_ERASE:  st_nxt  = S_EU0;
                        OP_IDENT:  st_nxt  = S_AUTO;
                        default:   drop    = 1'b1;
                     endcase
                  end
               end
               S_PROG: begin
                  go_prog = 1'b1;
                  st_nxt  = byp ? S_CMD : S_READ;
               end
               S_EU0: begin
                  if (hit_key_a && cmd == KEY_FIRST) st_nxt = S_EU1;
                  else                               drop = 1'b1;
               end
               S_EU1: begin
                  if (hit_key_b && cmd == KEY_SECOND) st_nxt = S_ECMD;
                  else                                drop = 1'b1;
               end
               S_ECMD: begin
                  if (cmd == OP_CHIP && hit_key_a) begin
                     go_chip = 1'b1;
                     st_nxt  = S_ERASE;
                  end else if (cmd == OP_SECT) begin
                     go_sect = 1'b1;
                     st_nxt  = S_ERASE;
                  end else begin
                     drop = 1'b1;
                  end
               end
               S_AUTO: begin
                  if (byp && cmd == OP_BYP_END)           drop = 1'b1;
                  else if (hit_query && cmd == OP_QUERY)  st_nxt = S_CFI;
                  else                                    drop = 1'b1;
               end
               default: drop = 1'b1;
            endcase
         end
         if (drop) begin
            st_nxt  = S_READ;
            byp_nxt = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= S_READ;
         byp <= 1'b0;
      end else begin
         st  <= st_nxt;
         byp <= byp_nxt;
      end
   end

   always_comb begin
      case (st)
         S_ERASE: rd_mode = MODE_STATUS;
         S_AUTO:  rd_mode = MODE_ID;
         S_CFI:   rd_mode = MODE_CFI;
         default: rd_mode = MODE_ARRAY;
      endcase
   end

endmodule

// File: rtl/nor_strobe_reg.sv
module nor_strobe_reg #(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 32,
   parameter int SECT_LOG2 = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_prog,
   input  logic              go_chip,
   input  logic              go_sect,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              prog_stb,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              chip_erase_stb,
   output logic              sect_erase_stb,
   output logic [ADDR_W-1:0] sect_base
);

   localparam int HI_W = ADDR_W - SECT_LOG2;

   logic [ADDR_W-1:0] aligned;
   assign aligned = {addr[ADDR_W-1 -: HI_W], {SECT_LOG2{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_stb       <= 1'b0;
         chip_erase_stb <= 1'b0;
         sect_erase_stb <= 1'b0;
         prog_addr      <= '0;
         prog_data      <= '0;
         sect_base      <= '0;
      end else begin
         prog_stb       <= go_prog;
         chip_erase_stb <= go_chip;
         sect_erase_stb <= go_sect;
         if (go_prog) begin
            prog_addr <= addr;
            prog_data <= data;
         end
         if (go_sect) sect_base <= aligned;
         else if (go_chip) sect_base <= '0;
      end
   end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 32,
   parameter int SECT_BYTES = 65536,
   parameter int NUM_SECT   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        wr_width,
   input  logic              erase_done,
   output logic [1:0]        rd_mode,
   output logic              prog_stb,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              chip_erase_stb,
   output logic              sect_erase_stb,
   output logic [ADDR_W-1:0] sect_base
);

   localparam int SECT_LOG2 = $clog2(SECT_BYTES);
   localparam int SECT_BITS = $clog2(NUM_SECT);

   if ((SECT_BYTES & (SECT_BYTES - 1)) != 0) begin : g_bad_sect_size
      $error("SECT_BYTES must be a power of two");
   end
   if ((NUM_SECT & (NUM_SECT - 1)) != 0 || NUM_SECT < 2) begin : g_bad_sect_count
      $error("NUM_SECT must be a power of two of at least 2");
   end
   if (SECT_LOG2 + SECT_BITS != ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W must cover exactly SECT_BYTES * NUM_SECT");
   end
   if (SECT_BYTES < 8192) begin : g_bad_key_reach
      $error("SECT_BYTES too small to hold keyed indices at 32-bit width");
   end
   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data_w
      $error("DATA_W must be 8..32");
   end

   logic hit_key_a, hit_key_b, hit_query;
   logic go_prog, go_chip, go_sect;

   nor_idx_match #(.SECT_LOG2(SECT_LOG2)) u_match (
      .sect_off   (wr_addr[SECT_LOG2-1:0]),
      .width_code (wr_width),
      .hit_key_a  (hit_key_a),
      .hit_key_b  (hit_key_b),
      .hit_query  (hit_query)
   );

   nor_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .cmd        (wr_data[7:0]),
      .hit_key_a  (hit_key_a),
      .hit_key_b  (hit_key_b),
      .hit_query  (hit_query),
      .erase_done (erase_done),
      .go_prog    (go_prog),
      .go_chip    (go_chip),
      .go_sect    (go_sect),
      .rd_mode    (rd_mode)
   );

   nor_strobe_reg #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SECT_LOG2 (SECT_LOG2)
   ) u_out (
      .clk            (clk),
      .rst_n          (rst_n),
      .go_prog        (go_prog),
      .go_chip        (go_chip),
      .go_sect        (go_sect),
      .addr           (wr_addr),
      .data           (wr_data),
      .prog_stb       (prog_stb),
      .prog_addr      (prog_addr),
      .prog_data      (prog_data),
      .chip_erase_stb (chip_erase_stb),
      .sect_erase_stb (sect_erase_stb),
      .sect_base      (sect_base)
   );

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] cmd,
   input logic       erase_done,
   input logic [1:0] rd_mode,
   input logic       prog_stb,
   input logic       chip_erase_stb,
   input logic       sect_erase_stb
);

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_stb, chip_erase_stb, sect_erase_stb}));

   // R4
   prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_stb |=> !prog_stb);

   // R8
   chip_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_stb |-> ($past(wr_en) && $past(cmd) == 8'h10));

   // R9
   erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_erase_stb || sect_erase_stb) |-> rd_mode == 2'd1);

   // R10
   erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode == 2'd1 && !erase_done) |=> rd_mode == 2'd1);

   // R10
   erase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode == 2'd1 && erase_done) |=> rd_mode != 2'd1);

   // R7
   query_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode == 2'd3 && wr_en) |=> rd_mode == 2'd0);

endmodule

bind nor_cmd_seq nor_seq_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .cmd            (wr_data[7:0]),
   .erase_done     (erase_done),
   .rd_mode        (rd_mode),
   .prog_stb       (prog_stb),
   .chip_erase_stb (chip_erase_stb),
   .sect_erase_stb (sect_erase_stb)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;
   localparam int DW = 32;
   localparam int EW = 2 + AW + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    wr_width = 2'd0;
   logic          erase_done = 1'b0;
   logic [1:0]    rd_mode;
   logic          prog_stb, chip_erase_stb, sect_erase_stb;
   logic [AW-1:0] prog_addr, sect_base;
   logic [DW-1:0] prog_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;
   logic [EW-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   nor_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_width(wr_width), .erase_done(erase_done),
      .rd_mode(rd_mode), .prog_stb(prog_stb), .prog_addr(prog_addr),
      .prog_data(prog_data), .chip_erase_stb(chip_erase_stb),
      .sect_erase_stb(sect_erase_stb), .sect_base(sect_base)
   );

   // Monitor: event kinds 1 program, 2 chip erase, 3 sector erase.
   always @(negedge clk) begin
      if (rst_n && (prog_stb || chip_erase_stb || sect_erase_stb)) begin
         logic [EW-1:0] act;
         logic [EW-1:0] exp;
         if (prog_stb)            act = {2'd1, prog_addr, prog_data};
         else if (chip_erase_stb) act = {2'd2, {AW{1'b0}}, {DW{1'b0}}};
         else                     act = {2'd3, sect_base, {DW{1'b0}}};
         n_vec++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4/R8/R9 unexpected strobe: actual %h expected none", act);
         end else begin
            exp = exp_q.pop_front();
            if (act !== exp) begin
               n_bad++;
               $display("FAIL R4/R8/R9 strobe: actual %h expected %h", act, exp);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   function automatic logic [AW-1:0] sc(input int idx, input logic [1:0] w);
      return AW'(idx << ((w == 2'd3) ? 2 : w));
   endfunction

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] w);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_width = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cmd3(input logic [1:0] w, input logic [7:0] c);
      wr(sc('h555, w), 32'hAA, w);
      wr(sc('h2AA, w), 32'h55, w);
      wr(sc('h555, w), {24'h0, c}, w);
   endtask

   task automatic erase_prefix(input logic [1:0] w);
      cmd3(w, 8'h80);
      wr(sc('h555, w), 32'hAA, w);
      wr(sc('h2AA, w), 32'h55, w);
   endtask

   task automatic done_pulse();
      @(negedge clk);
      erase_done = 1'b1;
      @(negedge clk);
      erase_done = 1'b0;
   endtask

   task automatic push(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_q.push_back({k, a, d});
   endtask

   task automatic chk_mode(input logic [1:0] exp, input string req);
      n_vec++;
      if (rd_mode !== exp) begin
         n_bad++;
         $display("FAIL %s rd_mode: actual %0d expected %0d", req, rd_mode, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_mode(2'd0, "R1");
      n_vec++;
      if (prog_stb || chip_erase_stb || sect_erase_stb) begin
         n_bad++;
         $display("FAIL R1 strobes: actual %b%b%b expected 000", prog_stb, chip_erase_stb, sect_erase_stb);
      end
      rst_n = 1'b1;

      // R2 R4: program at each width
      cmd3(2'd0, 8'hA0); push(2'd1, 20'h01234, 32'h0000005A); wr(20'h01234, 32'h5A, 2'd0);
      chk_mode(2'd0, "R4");
      cmd3(2'd1, 8'hA0); push(2'd1, 20'h02000, 32'hBEEF0012); wr(20'h02000, 32'hBEEF0012, 2'd1);
      cmd3(2'd2, 8'hA0); push(2'd1, 20'h3FFFC, 32'h12345678); wr(20'h3FFFC, 32'h12345678, 2'd2);
      cmd3(2'd3, 8'hA0); push(2'd1, 20'h00100, 32'h00000033); wr(20'h00100, 32'h33, 2'd3);
      // R4: 0xF0 as program data is programmed
      cmd3(2'd0, 8'hA0); push(2'd1, 20'h00040, 32'h000000F0); wr(20'h00040, 32'hF0, 2'd0);
      chk_mode(2'd0, "R4");

      // R3: broken second key, then no program may follow
      wr(20'h00555, 32'hAA, 2'd0); wr(20'h002AB, 32'h55, 2'd0);
      wr(20'h00555, 32'hA0, 2'd0); wr(20'h00010, 32'h77, 2'd0);
      chk_mode(2'd0, "R3");
      // R3: command at wrong index
      wr(20'h00555, 32'hAA, 2'd0); wr(20'h002AA, 32'h55, 2'd0);
      wr(20'h00556, 32'hA0, 2'd0); wr(20'h00011, 32'h66, 2'd0);
      chk_mode(2'd0, "R3");
      // R2: x8 indices at x16 width do not unlock
      cmd3(2'd0, 8'h90); chk_mode(2'd2, "R6");
      wr(20'h0, 32'h00, 2'd0); chk_mode(2'd0, "R6");
      wr(20'h00555, 32'hAA, 2'd1); wr(20'h002AA, 32'h55, 2'd1); wr(20'h00555, 32'h90, 2'd1);
      chk_mode(2'd0, "R2");

      // R5: 0xF0 from identification and after first key
      cmd3(2'd1, 8'h90); chk_mode(2'd2, "R5");
      wr(20'h00003, 32'hF0, 2'd1); chk_mode(2'd0, "R5");
      wr(20'h00555, 32'hAA, 2'd0); wr(20'h00009, 32'hF0, 2'd0);
      wr(20'h002AA, 32'h55, 2'd0); wr(20'h00555, 32'hA0, 2'd0); wr(20'h00020, 32'h11, 2'd0);
      chk_mode(2'd0, "R5");

      // R7: query entry from array and from identification
      wr(20'h00055, 32'h98, 2'd0); chk_mode(2'd3, "R7");
      wr(20'h00000, 32'h12, 2'd0); chk_mode(2'd0, "R7");
      wr(20'h000AA, 32'h98, 2'd1); chk_mode(2'd3, "R7");
      wr(20'h00055, 32'h98, 2'd0); chk_mode(2'd0, "R7");
      cmd3(2'd2, 8'h90); chk_mode(2'd2, "R7");
      wr(20'h00154, 32'h98, 2'd2); chk_mode(2'd3, "R7");
      wr(20'h00000, 32'hF0, 2'd2); chk_mode(2'd0, "R7");

      // R13: unknown command
      cmd3(2'd0, 8'h77); chk_mode(2'd0, "R13");
      wr(20'h00030, 32'h12, 2'd0); chk_mode(2'd0, "R13");

      // R8: chip erase, R10 writes ignored while erasing
      erase_prefix(2'd0); push(2'd2, '0, '0); wr(20'h00555, 32'h10, 2'd0);
      chk_mode(2'd1, "R8");
      wr(20'h00555, 32'hF0, 2'd0); chk_mode(2'd1, "R10");
      wr(20'h00555, 32'hAA, 2'd0); chk_mode(2'd1, "R10");
      done_pulse(); chk_mode(2'd0, "R10");
      // R8: 0x10 at wrong index aborts
      erase_prefix(2'd0); wr(20'h00100, 32'h10, 2'd0); chk_mode(2'd0, "R8");

      // R9: sector erase with alignment
      erase_prefix(2'd1); push(2'd3, 20'h30000, '0); wr(20'h3ABCD, 32'h30, 2'd1);
      chk_mode(2'd1, "R9");
      done_pulse(); chk_mode(2'd0, "R9");

      // R11: bypass, single-write commands at any address
      cmd3(2'd0, 8'h20); chk_mode(2'd0, "R11");
      wr(20'h00007, 32'hA0, 2'd0); push(2'd1, 20'h00500, 32'h3C); wr(20'h00500, 32'h3C, 2'd0);
      wr(20'h00009, 32'hA0, 2'd0); push(2'd1, 20'h00501, 32'h0F); wr(20'h00501, 32'h0F, 2'd0);
      wr(20'h00001, 32'h80, 2'd0); wr(20'h00555, 32'hAA, 2'd0); wr(20'h002AA, 32'h55, 2'd0);
      push(2'd3, 20'hF0000, '0); wr(20'hF1234, 32'h30, 2'd0); chk_mode(2'd1, "R11");
      done_pulse(); chk_mode(2'd0, "R11");
      wr(20'h00003, 32'hA0, 2'd0); push(2'd1, 20'h00010, 32'h01); wr(20'h00010, 32'h01, 2'd0);

      // R10: write in the same cycle as erase_done is ignored
      wr(20'h00002, 32'h80, 2'd0); wr(20'h00555, 32'hAA, 2'd0); wr(20'h002AA, 32'h55, 2'd0);
      push(2'd3, 20'h20000, '0); wr(20'h2FFFF, 32'h30, 2'd0);
      @(negedge clk);
      erase_done = 1'b1; wr_en = 1'b1; wr_addr = 20'h00555; wr_data = 32'hA0; wr_width = 2'd0;
      @(negedge clk);
      erase_done = 1'b0; wr_en = 1'b0;
      chk_mode(2'd0, "R10");
      wr(20'h00022, 32'h12, 2'd0); chk_mode(2'd0, "R10");

      // R12: bypass exit
      cmd3(2'd0, 8'h20);
      wr(20'h00000, 32'h90, 2'd0); chk_mode(2'd2, "R12");
      wr(20'h00000, 32'h00, 2'd0); chk_mode(2'd0, "R12");
      wr(20'h00005, 32'hA0, 2'd0); wr(20'h00006, 32'h11, 2'd0); chk_mode(2'd0, "R12");

      repeat (3) @(negedge clk);
      n_vec++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R4/R8/R9 missing strobes: actual %0d pending expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule